// File: doc/BRIEF.md
# Segmented Program Address Generator

This block builds 20-bit physical program-memory addresses out of a 4-bit segment number and a 16-bit offset. It keeps two segment registers. The code segment selects where instructions are fetched. The table segment selects where table reads and compares fetch their data. Offset arithmetic and the program-counter increment stay inside 16 bits. A carry or borrow out of the offset is dropped, so the segment never moves by itself. Execution therefore stays inside one 64K segment until a far transfer reloads the code segment.

The table segment sits on a small special-function-register bus at address 0008H and is readable and writable there. The code segment cannot be reached from that bus. It changes only in three ways: a far-transfer request (far jump, far call, vector call or far return), a return-from-interrupt restore, or interrupt entry. On interrupt entry the block emits the current code segment and program counter on a push stream, for the stack logic outside the block to store.

The push stream uses valid/ready. Once `push_valid` is high, `push_data` and `push_seg` hold steady until a cycle in which `push_ready` is high. An interrupt request is a valid/ready input. `irq_ready` is high only while the push holding stage is empty or is draining in the same cycle. The interrupt is accepted only in a cycle where `irq_valid` and `irq_ready` are both high. Every other pin is plain control or data with no handshake.

Top module: `seg_addr_gen`

## Requirements
- R1: Both segment registers store only 4 bits. Bits 7:4 of `code_seg`, `table_seg` and `sfr_rdata` always read as 0.
- R2: After reset, `code_seg` = 00H, `table_seg` = 00H and `push_valid` = 0.
- R3: When `far_valid` is sampled high at a rising edge, `code_seg` equals `{4'b0, far_seg[3:0]}` after that edge. Bits 7:4 of `far_seg` are discarded.
- R4: A write with `sfr_we` = 1 and `sfr_addr` = 0008H loads `sfr_wdata[3:0]` into the table segment on the next edge. Reading at 0008H returns `{4'b0, table_seg}`. Any other address reads 00H, and a write there changes neither segment register.
- R5: `pc_next` = (`pc_in` + 1) mod 2^16, so FFFFH wraps to 0000H. `code_seg` does not change because of this.
- R6: With `addr_sel` = 0, `phys_addr` = `{code_seg[3:0], pc_in}`.
- R7: With `addr_sel` = 1, `phys_addr` = `{table_seg[3:0], (tbl_base + tbl_disp) mod 2^16}`. A carry or borrow out of the offset never touches the segment field.
- R8: An accepted interrupt does three things on the edge: `push_data` is loaded with `{code_seg, pc_in}` (segment byte in bits 23:16), `push_seg` is loaded with `exp_mode`, and `push_valid` is set. `code_seg` becomes 00H, unless a far load or a restore is requested in the same cycle.
- R9: While `push_valid` = 1 and `push_ready` = 0, `push_valid`, `push_data` and `push_seg` stay unchanged. `irq_ready` = !`push_valid` | `push_ready`. A handshake with no new accept clears `push_valid`.
- R10: If a far load and an interrupt accept happen in the same cycle, the push holds the code segment from before the edge, and `code_seg` takes the far target.
- R11: When `rti_valid` is sampled high, `code_seg` becomes `{4'b0, rti_seg[3:0]}`. The load sources rank far load first, then restore, then interrupt entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| far_valid | input | 1 | Far-transfer load of the code segment |
| far_seg | input | 8 | Target segment of the far transfer |
| rti_valid | input | 1 | Return-from-interrupt restore |
| rti_seg | input | 8 | Segment byte popped from the stack |
| irq_valid | input | 1 | Interrupt entry request |
| irq_ready | output | 1 | Interrupt entry can be accepted |
| exp_mode | input | 1 | Expanded (1MB) program space is active |
| push_valid | output | 1 | Push stream word valid |
| push_ready | input | 1 | Push stream consumer ready |
| push_data | output | 24 | Saved segment byte (23:16) and PC (15:0) |
| push_seg | output | 1 | Segment byte must be stacked (expanded mode) |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 16 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for `sfr_addr` |
| pc_in | input | 16 | Current program counter |
| pc_next | output | 16 | Incremented PC, wrapping in segment |
| tbl_base | input | 16 | Table access base offset |
| tbl_disp | input | 16 | Table displacement (two's complement) |
| addr_sel | input | 1 | 0 selects code address, 1 table address |
| phys_addr | output | 20 | Physical program-memory address |
| code_seg | output | 8 | Code segment register value |
| table_seg | output | 8 | Table segment register value |

## Verification
Some properties are checked every cycle. These are the zero upper nibbles, the code segment staying put when no load source fires, the far and restore loads landing one edge later, the push word holding under back-pressure, the pre-update segment being captured on interrupt entry, and the in-segment wrap of both offset paths. Other behaviour is shown only by the bench's scenarios. This covers the priority between simultaneous load sources, SFR writes to neighbouring addresses leaving both registers alone, and the table segment reading back through the bus after random write sequences. It also covers long stretches of stalled and draining push traffic mixed with far transfers.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_W_D   = 4;
  localparam int REG_W_D   = 8;
  localparam int OFS_W_D   = 16;
  localparam int SFR_AW_D  = 16;
  localparam int TSR_ADR_D = 16'h0008;

  // Source that updates the code segment on the next edge, in priority order
  typedef enum logic [1:0] {
    CS_HOLD = 2'd0,
    CS_FAR  = 2'd1,
    CS_RTI  = 2'd2,
    CS_IRQ  = 2'd3
  } cs_src_e;
endpackage

// File: rtl/seg_code_reg.sv
module seg_code_reg
  import seg_pkg::*;
#(
  parameter int SEG_W = SEG_W_D,
  parameter int REG_W = REG_W_D,
  parameter int OFS_W = OFS_W_D
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   far_valid,
  input  logic [REG_W-1:0]       far_seg,
  input  logic                   rti_valid,
  input  logic [REG_W-1:0]       rti_seg,
  input  logic                   irq_valid,
  output logic                   irq_ready,
  input  logic                   exp_mode,
  input  logic [OFS_W-1:0]       pc_in,
  output logic                   push_valid,
  input  logic                   push_ready,
  output logic [REG_W+OFS_W-1:0] push_data,
  output logic                   push_seg,
  output logic [SEG_W-1:0]       seg_q
);
  localparam int PAD_W = REG_W - SEG_W;

  cs_src_e          src;
  logic             irq_acc;
  logic [SEG_W-1:0] seg_d;

  assign irq_ready = !push_valid || push_ready;
  assign irq_acc   = irq_valid && irq_ready;

  always_comb begin
    if (far_valid)      src = CS_FAR;
    else if (rti_valid) src = CS_RTI;
    else if (irq_acc)   src = CS_IRQ;
    else                src = CS_HOLD;
  end

  always_comb begin
    unique case (src)
      CS_FAR:  seg_d = far_seg[SEG_W-1:0];
      CS_RTI:  seg_d = rti_seg[SEG_W-1:0];
      CS_IRQ:  seg_d = '0;
      default: seg_d = seg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_q <= '0;
    else        seg_q <= seg_d;
  end

  // Push holding stage: captures the value before any same-cycle update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_valid <= 1'b0;
      push_data  <= '0;
      push_seg   <= 1'b0;
    end else if (irq_acc) begin
      push_valid <= 1'b1;
      push_data  <= {{PAD_W{1'b0}}, seg_q, pc_in};
      push_seg   <= exp_mode;
    end else if (push_ready) begin
      push_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_table_reg.sv
module seg_table_reg
  import seg_pkg::*;
#(
  parameter int SEG_W   = SEG_W_D,
  parameter int REG_W   = REG_W_D,
  parameter int SFR_AW  = SFR_AW_D,
  parameter int TSR_ADR = TSR_ADR_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SFR_AW-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [SEG_W-1:0]  seg_q
);
  localparam int PAD_W = REG_W - SEG_W;
  localparam logic [SFR_AW-1:0] HIT_ADR = SFR_AW'(TSR_ADR);

  logic hit;
  assign hit = (addr == HIT_ADR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seg_q <= '0;
    else if (we && hit) seg_q <= wdata[SEG_W-1:0];
  end

  assign rdata = hit ? {{PAD_W{1'b0}}, seg_q} : '0;
endmodule

// File: rtl/seg_offset_alu.sv
module seg_offset_alu
  import seg_pkg::*;
#(
  parameter int OFS_W = OFS_W_D
) (
  input  logic [OFS_W-1:0] pc_in,
  output logic [OFS_W-1:0] pc_next,
  input  logic [OFS_W-1:0] base,
  input  logic [OFS_W-1:0] disp,
  output logic [OFS_W-1:0] tbl_ofs
);
  // Both sums are truncated to the offset width; the carry is discarded
  logic [OFS_W:0] pc_sum;
  logic [OFS_W:0] tb_sum;

  assign pc_sum  = {1'b0, pc_in} + {{OFS_W{1'b0}}, 1'b1};
  assign tb_sum  = {1'b0, base} + {1'b0, disp};
  assign pc_next = pc_sum[OFS_W-1:0];
  assign tbl_ofs = tb_sum[OFS_W-1:0];
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
#(
  parameter int SEG_W   = SEG_W_D,
  parameter int REG_W   = REG_W_D,
  parameter int OFS_W   = OFS_W_D,
  parameter int SFR_AW  = SFR_AW_D,
  parameter int TSR_ADR = TSR_ADR_D
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   far_valid,
  input  logic [REG_W-1:0]       far_seg,
  input  logic                   rti_valid,
  input  logic [REG_W-1:0]       rti_seg,
  input  logic                   irq_valid,
  output logic                   irq_ready,
  input  logic                   exp_mode,
  output logic                   push_valid,
  input  logic                   push_ready,
  output logic [REG_W+OFS_W-1:0] push_data,
  output logic                   push_seg,
  input  logic                   sfr_we,
  input  logic [SFR_AW-1:0]      sfr_addr,
  input  logic [REG_W-1:0]       sfr_wdata,
  output logic [REG_W-1:0]       sfr_rdata,
  input  logic [OFS_W-1:0]       pc_in,
  output logic [OFS_W-1:0]       pc_next,
  input  logic [OFS_W-1:0]       tbl_base,
  input  logic [OFS_W-1:0]       tbl_disp,
  input  logic                   addr_sel,
  output logic [SEG_W+OFS_W-1:0] phys_addr,
  output logic [REG_W-1:0]       code_seg,
  output logic [REG_W-1:0]       table_seg
);
  localparam int PAD_W = REG_W - SEG_W;

  logic [SEG_W-1:0] cs_q;
  logic [SEG_W-1:0] ts_q;
  logic [OFS_W-1:0] tbl_ofs;

  seg_code_reg #(.SEG_W(SEG_W), .REG_W(REG_W), .OFS_W(OFS_W)) u_code (
    .clk        (clk),
    .rst_n      (rst_n),
    .far_valid  (far_valid),
    .far_seg    (far_seg),
    .rti_valid  (rti_valid),
    .rti_seg    (rti_seg),
    .irq_valid  (irq_valid),
    .irq_ready  (irq_ready),
    .exp_mode   (exp_mode),
    .pc_in      (pc_in),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_data  (push_data),
    .push_seg   (push_seg),
    .seg_q      (cs_q)
  );

  seg_table_reg #(.SEG_W(SEG_W), .REG_W(REG_W), .SFR_AW(SFR_AW), .TSR_ADR(TSR_ADR)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sfr_we),
    .addr  (sfr_addr),
    .wdata (sfr_wdata),
    .rdata (sfr_rdata),
    .seg_q (ts_q)
  );

  seg_offset_alu #(.OFS_W(OFS_W)) u_alu (
    .pc_in   (pc_in),
    .pc_next (pc_next),
    .base    (tbl_base),
    .disp    (tbl_disp),
    .tbl_ofs (tbl_ofs)
  );

  always_comb begin
    if (addr_sel) phys_addr = {ts_q, tbl_ofs};
    else          phys_addr = {cs_q, pc_in};
  end

  assign code_seg  = {{PAD_W{1'b0}}, cs_q};
  assign table_seg = {{PAD_W{1'b0}}, ts_q};
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        far_valid,
  input logic [7:0]  far_seg,
  input logic        rti_valid,
  input logic [7:0]  rti_seg,
  input logic        irq_valid,
  input logic        irq_ready,
  input logic        push_valid,
  input logic        push_ready,
  input logic [23:0] push_data,
  input logic        push_seg,
  input logic [7:0]  sfr_rdata,
  input logic [15:0] pc_in,
  input logic [15:0] pc_next,
  input logic [15:0] tbl_base,
  input logic [15:0] tbl_disp,
  input logic        addr_sel,
  input logic [19:0] phys_addr,
  input logic [7:0]  code_seg,
  input logic [7:0]  table_seg
);
  logic acc;
  assign acc = irq_valid && irq_ready;

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (code_seg[7:4] == 4'h0) && (table_seg[7:4] == 4'h0) && (sfr_rdata[7:4] == 4'h0));

  p_csr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!far_valid && !rti_valid && !acc) |=> $stable(code_seg));

  p_far_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    far_valid |=> (code_seg == {4'h0, $past(far_seg[3:0])}));

  p_rti_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rti_valid && !far_valid) |=> (code_seg == {4'h0, $past(rti_seg[3:0])}));

  p_pc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_in == 16'hFFFF) |-> (pc_next == 16'h0000));

  p_code_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_sel |-> (phys_addr == {code_seg[3:0], pc_in}));

  p_tbl_seg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_sel |-> (phys_addr[19:16] == table_seg[3:0]) && (phys_addr[15:0] == tbl_base + tbl_disp));

  p_push_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> push_valid && $stable(push_data) && $stable(push_seg));

  p_save_pre_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> push_valid && (push_data == {$past(code_seg), $past(pc_in)}));
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .far_valid  (far_valid),
  .far_seg    (far_seg),
  .rti_valid  (rti_valid),
  .rti_seg    (rti_seg),
  .irq_valid  (irq_valid),
  .irq_ready  (irq_ready),
  .push_valid (push_valid),
  .push_ready (push_ready),
  .push_data  (push_data),
  .push_seg   (push_seg),
  .sfr_rdata  (sfr_rdata),
  .pc_in      (pc_in),
  .pc_next    (pc_next),
  .tbl_base   (tbl_base),
  .tbl_disp   (tbl_disp),
  .addr_sel   (addr_sel),
  .phys_addr  (phys_addr),
  .code_seg   (code_seg),
  .table_seg  (table_seg)
);

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 1500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        far_valid = 0, rti_valid = 0, irq_valid = 0, exp_mode = 0;
  logic [7:0]  far_seg = 0, rti_seg = 0, sfr_wdata = 0;
  logic        push_ready = 0, sfr_we = 0, addr_sel = 0;
  logic [15:0] sfr_addr = 0, pc_in = 0, tbl_base = 0, tbl_disp = 0;
  logic        irq_ready, push_valid, push_seg;
  logic [23:0] push_data;
  logic [7:0]  sfr_rdata, code_seg, table_seg;
  logic [15:0] pc_next;
  logic [19:0] phys_addr;

  int n_chk = 0, n_fail = 0;

  // Reference state
  logic [3:0]  m_cs = 0, m_ts = 0;
  logic        m_pv = 0, m_ps = 0;
  logic [23:0] m_pd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .far_valid(far_valid), .far_seg(far_seg),
    .rti_valid(rti_valid), .rti_seg(rti_seg), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .exp_mode(exp_mode), .push_valid(push_valid),
    .push_ready(push_ready), .push_data(push_data), .push_seg(push_seg),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .pc_in(pc_in), .pc_next(pc_next),
    .tbl_base(tbl_base), .tbl_disp(tbl_disp), .addr_sel(addr_sel),
    .phys_addr(phys_addr), .code_seg(code_seg), .table_seg(table_seg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_addr(input logic sel, input logic [3:0] cs,
      input logic [3:0] ts, input logic [15:0] pc, input logic [15:0] b, input logic [15:0] d);
    logic [15:0] o;
    o = b + d;
    return sel ? {ts, o} : {cs, pc};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input logic [3:0] ts);
    return (a == 16'h0008) ? {4'h0, ts} : 8'h00;
  endfunction

  // One cycle: inputs already driven after a falling edge
  task automatic step();
    logic acc;
    #1;
    chk("R5 pc_next", {16'h0, pc_next}, {16'h0, pc_in + 16'd1});
    chk(addr_sel ? "R7 table addr" : "R6 code addr", {12'h0, phys_addr},
        {12'h0, exp_addr(addr_sel, m_cs, m_ts, pc_in, tbl_base, tbl_disp)});
    chk("R4 sfr read", {24'h0, sfr_rdata}, {24'h0, exp_rd(sfr_addr, m_ts)});
    chk("R9 irq_ready", {31'h0, irq_ready}, {31'h0, !m_pv || push_ready});
    acc = irq_valid && (!m_pv || push_ready);
    if (acc) begin
      m_pd = {4'h0, m_cs, pc_in};
      m_ps = exp_mode;
      m_pv = 1'b1;
    end else if (push_ready) m_pv = 1'b0;
    if (far_valid)      m_cs = far_seg[3:0];
    else if (rti_valid) m_cs = rti_seg[3:0];
    else if (acc)       m_cs = 4'h0;
    if (sfr_we && sfr_addr == 16'h0008) m_ts = sfr_wdata[3:0];
    @(posedge clk);
    @(negedge clk);
    chk("R3/R8/R11 code_seg", {24'h0, code_seg}, {28'h0, m_cs});
    chk("R4 table_seg", {24'h0, table_seg}, {28'h0, m_ts});
    chk("R9 push_valid", {31'h0, push_valid}, {31'h0, m_pv});
    if (m_pv) begin
      chk("R8/R10 push_data", {8'h0, push_data}, {8'h0, m_pd});
      chk("R8 push_seg", {31'h0, push_seg}, {31'h0, m_ps});
    end
  endtask

  task automatic idle();
    far_valid = 0; rti_valid = 0; irq_valid = 0; sfr_we = 0; push_ready = 0;
  endtask

  task automatic randomize_inputs();
    logic [3:0] r;
    r = 4'($urandom_range(0, 15));
    far_valid  = (r < 3);
    rti_valid  = ($urandom_range(0, 9) == 0);
    irq_valid  = ($urandom_range(0, 3) == 0);
    push_ready = ($urandom_range(0, 2) != 0);
    exp_mode   = 1'($urandom);
    far_seg    = 8'($urandom);
    rti_seg    = 8'($urandom);
    sfr_we     = ($urandom_range(0, 2) == 0);
    sfr_addr   = ($urandom_range(0, 1) == 0) ? 16'h0008 : 16'($urandom_range(0, 16));
    sfr_wdata  = 8'($urandom);
    pc_in      = ($urandom_range(0, 7) == 0) ? 16'hFFFF : 16'($urandom);
    tbl_base   = 16'($urandom);
    tbl_disp   = 16'($urandom);
    addr_sel   = 1'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    // R2 reset state
    chk("R2 code_seg reset", {24'h0, code_seg}, 32'h0);
    chk("R2 table_seg reset", {24'h0, table_seg}, 32'h0);
    chk("R2 push_valid reset", {31'h0, push_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 truncation of a wide target, R1 upper bits zero
    idle(); far_valid = 1; far_seg = 8'hFF; step();
    chk("R1 code_seg upper", {28'h0, code_seg[7:4]}, 32'h0);
    // R5 wrap keeps segment
    idle(); pc_in = 16'hFFFF; addr_sel = 0; step();
    // R7 carry and borrow out of the offset
    idle(); addr_sel = 1; tbl_base = 16'hFFFF; tbl_disp = 16'h0002; step();
    idle(); addr_sel = 1; tbl_base = 16'h0000; tbl_disp = 16'hFFFF; step();
    // R4 write table segment with ones in the upper nibble, then neighbour writes
    idle(); sfr_we = 1; sfr_addr = 16'h0008; sfr_wdata = 8'hFA; step();
    chk("R1 table_seg upper", {24'h0, table_seg}, 32'h0A);
    idle(); sfr_we = 1; sfr_addr = 16'h0009; sfr_wdata = 8'h03; step();
    idle(); sfr_we = 1; sfr_addr = 16'h0000; sfr_wdata = 8'h05; step();
    chk("R4 no write to code via sfr", {24'h0, code_seg}, 32'h0F);
    // R10 interrupt and far load together
    idle(); irq_valid = 1; far_valid = 1; far_seg = 8'h06; pc_in = 16'h1234;
    exp_mode = 1; step();
    // R9 back-pressure: stalled push, irq refused
    idle(); irq_valid = 1; pc_in = 16'h4444; step();
    idle(); step();
    // R8 accept while draining, code segment cleared
    idle(); push_ready = 1; irq_valid = 1; pc_in = 16'h5555; exp_mode = 0; step();
    idle(); push_ready = 1; step();
    // R11 restore, and priority over irq
    idle(); rti_valid = 1; rti_seg = 8'h9C; irq_valid = 1; step();
    idle(); far_valid = 1; far_seg = 8'h02; rti_valid = 1; rti_seg = 8'h07; step();

    for (int i = 0; i < N_RAND; i++) begin
      randomize_inputs();
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule